// File: doc/BRIEF.md
# Fast-Lock and Phase-Resync Timer

This block is a timer that runs on the phase-detector clock of a fractional-N synthesizer and works in one of two modes, chosen by a 2-bit mode input. In fast-lock mode, each rising edge on the load-enable input marks a new frequency write. The edge starts a one-shot window whose length in clock cycles is the programmed divider value. For the length of that window the block raises a charge-pump current-boost output and a fast-lock switch output. Both drop together when the window ends. The switch can also be routed to an open-drain style pin-ground request, but only when a 4-bit output-select code chooses it.

In phase-resync mode, a cascade of two counters produces a one-cycle sync pulse every divider × modulus clock cycles. A load-enable edge restarts the cascade. The second sync pulse after that edge is marked as the resync event. The first pulse is not marked, and neither is any pulse after the second. In the two remaining mode codes the block is idle.

Top module: `flk_resync_timer`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every output is 0.
- R2: With mode 01, a load-enable rising edge sampled on a clock edge raises boost_o from that edge for exactly N cycles, where N is div_i, and a div_i of 0 counts as 1.
- R3: fl_sw_o rises and falls on the same clock edges as boost_o.
- R4: A load-enable rising edge while the fast-lock window is open restarts the window at the full length N, counted from the new edge.
- R5: mux_gnd_o equals fl_sw_o when muxsel_i is 4'b1100, and is 0 for any other select code.
- R6: With mode 10, sync_o is a one-cycle pulse that first appears P cycles after the restarting edge and then every P cycles, where P = N × M, M is mod_i, and an M below 2 counts as 2.
- R7: resync_o is a one-cycle pulse that coincides with the second sync pulse after a load-enable rising edge, and with no other sync pulse. Without an edge since reset or since mode 10 was entered, it never fires.
- R8: A load-enable rising edge in mode 10 clears the sync cascade, so no sync pulse follows that edge, and the next sync comes P cycles later.
- R9: boost_o, fl_sw_o and mux_gnd_o are 0 whenever the mode sampled on the previous edge was not 01. sync_o and resync_o are 0 whenever it was not 10. In modes 00 and 11 all outputs stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | 00 idle, 01 fast-lock, 10 phase-resync, 11 idle |
| div_i | input | 12 | Divider value N; 0 is treated as 1 |
| mod_i | input | 12 | Fractional modulus M; values below 2 are treated as 2 |
| le_i | input | 1 | Load-enable level; its rising edge marks a frequency write |
| muxsel_i | input | 4 | Output-select code; 4'b1100 routes the switch to the pin-ground request |
| boost_o | output | 1 | Charge-pump current boost to maximum |
| fl_sw_o | output | 1 | Fast-lock loop-filter switch active |
| mux_gnd_o | output | 1 | Request to short the multiplexed output pin to ground |
| sync_o | output | 1 | Periodic sync pulse |
| resync_o | output | 1 | Phase-resync event (second sync after a write) |

## Verification
The bench targets window-length errors. A design that is off by one on the timeout would hold the boost for 519 or 521 cycles on a 520-cycle setting. One that ignores the zero clamp would hold it for 4096 cycles. Restarts are driven in the middle of a window and in the middle of a sync period. A design that ignored them would drop the boost early, or it would produce a sync pulse at the old phase and flag the wrong pulse as the resync event. Randomized segments switch between all four modes, push small divider and modulus values (including the clamped ones), and toggle the output select. This exposes sync pulses that leak into the wrong mode, a resync flag on the first or third pulse, and ground requests that ignore the select code.

// File: rtl/flk_pkg.sv
package flk_pkg;

   typedef enum logic [1:0] {
      MODE_IDLE     = 2'b00,
      MODE_FASTLOCK = 2'b01,
      MODE_RESYNC   = 2'b10,
      MODE_SPARE    = 2'b11
   } flk_mode_e;

   localparam int FLK_SEL_W   = 4;
   localparam int FLK_CNT_W   = 12;

endpackage

// File: rtl/flk_le_edge.sv
module flk_le_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic le_i,
   output logic rise_o
);

   logic le_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         le_q <= 1'b0;
      end else begin
         le_q <= le_i;
      end
   end

   assign rise_o = le_i & ~le_q;

endmodule

// File: rtl/flk_oneshot.sv
module flk_oneshot #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             start_i,
   input  logic [CNT_W-1:0] len_i,
   output logic             active_o
);

   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   if (CNT_W < 2) begin : g_bad_width
      $error("flk_oneshot: CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] len_eff;
   logic             active_q;

   // a zero length would otherwise wrap to a full-range window
   assign len_eff = (len_i == '0) ? ONE : len_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         remain_q <= '0;
      end else if (!en_i) begin
         active_q <= 1'b0;
         remain_q <= '0;
      end else if (start_i) begin
         active_q <= 1'b1;
         remain_q <= len_eff;
      end else if (active_q) begin
         if (remain_q <= ONE) begin
            active_q <= 1'b0;
            remain_q <= '0;
         end else begin
            remain_q <= remain_q - ONE;
         end
      end
   end

   assign active_o = active_q;

endmodule

// File: rtl/flk_sync_gen.sv
module flk_sync_gen #(
   parameter int DIV_W      = 12,
   parameter int MOD_W      = 12,
   parameter int RESYNC_IDX = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             restart_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [MOD_W-1:0] mod_i,
   output logic             sync_o,
   output logic             resync_o
);

   localparam int               SEEN_W   = $clog2(RESYNC_IDX + 1);
   localparam logic [SEEN_W-1:0] SEEN_SAT = SEEN_W'(RESYNC_IDX);
   localparam logic [SEEN_W-1:0] SEEN_HIT = SEEN_W'(RESYNC_IDX - 1);
   localparam logic [SEEN_W-1:0] SEEN_ONE = SEEN_W'(1);
   localparam logic [DIV_W-1:0]  D_ONE    = DIV_W'(1);
   localparam logic [MOD_W-1:0]  M_ONE    = MOD_W'(1);
   localparam logic [MOD_W-1:0]  M_TWO    = MOD_W'(2);

   if (RESYNC_IDX < 1) begin : g_bad_idx
      $error("flk_sync_gen: RESYNC_IDX must be at least 1");
   end
   if (MOD_W < 2 || DIV_W < 2) begin : g_bad_width
      $error("flk_sync_gen: counter widths must be at least 2");
   end

   logic [MOD_W-1:0]  pre_q;
   logic [DIV_W-1:0]  div_q;
   logic [SEEN_W-1:0] seen_q;
   logic              sync_q;
   logic              resync_q;
   logic [MOD_W-1:0]  mod_last;
   logic [DIV_W-1:0]  div_last;
   logic              pre_wrap;
   logic              terminal;

   assign mod_last = ((mod_i < M_TWO) ? M_TWO : mod_i) - M_ONE;
   assign div_last = ((div_i == '0) ? D_ONE : div_i) - D_ONE;
   // >= so that a value shrunk mid-period cannot strand the count
   assign pre_wrap = (pre_q >= mod_last);
   assign terminal = pre_wrap && (div_q >= div_last);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pre_q    <= '0;
         div_q    <= '0;
         seen_q   <= SEEN_SAT;
         sync_q   <= 1'b0;
         resync_q <= 1'b0;
      end else if (!en_i) begin
         pre_q    <= '0;
         div_q    <= '0;
         seen_q   <= SEEN_SAT;
         sync_q   <= 1'b0;
         resync_q <= 1'b0;
      end else if (restart_i) begin
         pre_q    <= '0;
         div_q    <= '0;
         seen_q   <= '0;
         sync_q   <= 1'b0;
         resync_q <= 1'b0;
      end else begin
         if (pre_wrap) begin
            pre_q <= '0;
            div_q <= terminal ? '0 : div_q + D_ONE;
         end else begin
            pre_q <= pre_q + M_ONE;
         end
         sync_q   <= terminal;
         resync_q <= terminal && (seen_q == SEEN_HIT);
         if (terminal && (seen_q < SEEN_SAT)) begin
            seen_q <= seen_q + SEEN_ONE;
         end
      end
   end

   assign sync_o   = sync_q;
   assign resync_o = resync_q;

endmodule

// File: rtl/flk_resync_timer.sv
module flk_resync_timer #(
   parameter int                 DIV_W      = 12,
   parameter int                 MOD_W      = 12,
   parameter int                 SEL_W      = 4,
   parameter logic [SEL_W-1:0]   GND_CODE   = SEL_W'(4'b1100),
   parameter int                 RESYNC_IDX = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic [MOD_W-1:0] mod_i,
   input  logic             le_i,
   input  logic [SEL_W-1:0] muxsel_i,
   output logic             boost_o,
   output logic             fl_sw_o,
   output logic             mux_gnd_o,
   output logic             sync_o,
   output logic             resync_o
);
   import flk_pkg::*;

   if (SEL_W < 4) begin : g_bad_sel
      $error("flk_resync_timer: SEL_W must hold the ground code");
   end

   flk_mode_e mode;
   logic      le_rise;
   logic      fl_en;
   logic      rs_en;
   logic      fl_active;

   assign mode  = flk_mode_e'(mode_i);
   assign fl_en = (mode == MODE_FASTLOCK);
   assign rs_en = (mode == MODE_RESYNC);

   flk_le_edge u_edge (
      .clk    (clk),
      .rst_n  (rst_n),
      .le_i   (le_i),
      .rise_o (le_rise)
   );

   flk_oneshot #(.CNT_W(DIV_W)) u_oneshot (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (fl_en),
      .start_i  (le_rise),
      .len_i    (div_i),
      .active_o (fl_active)
   );

   flk_sync_gen #(
      .DIV_W      (DIV_W),
      .MOD_W      (MOD_W),
      .RESYNC_IDX (RESYNC_IDX)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (rs_en),
      .restart_i (le_rise),
      .div_i     (div_i),
      .mod_i     (mod_i),
      .sync_o    (sync_o),
      .resync_o  (resync_o)
   );

   assign boost_o   = fl_active;
   assign fl_sw_o   = fl_active;
   assign mux_gnd_o = fl_active && (muxsel_i == GND_CODE);

endmodule

// File: rtl/flk_resync_timer_chk.sv
module flk_resync_timer_chk #(
   parameter int SEL_W = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       mode_i,
   input logic             le_i,
   input logic [SEL_W-1:0] muxsel_i,
   input logic             boost_o,
   input logic             fl_sw_o,
   input logic             mux_gnd_o,
   input logic             sync_o,
   input logic             resync_o
);

   logic le_seen_q;
   logic le_up;

   always_ff @(posedge clk) begin
      if (!rst_n) le_seen_q <= 1'b0;
      else        le_seen_q <= le_i;
   end
   assign le_up = le_i && !le_seen_q;

   p_idle_after_reset_r1: assert property (@(posedge clk)
      $rose(rst_n) |-> !(boost_o || fl_sw_o || mux_gnd_o || sync_o || resync_o));

   p_boost_starts_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (le_up && mode_i == 2'b01) |=> boost_o);

   p_switch_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(boost_o) |-> !fl_sw_o);

   p_gnd_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mux_gnd_o |-> (muxsel_i == SEL_W'(4'b1100)));

   p_sync_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sync_o |=> !sync_o);

   p_resync_on_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resync_o |-> sync_o);

   p_resync_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resync_o |=> !resync_o);

   p_restart_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (le_up && mode_i == 2'b10) |=> !sync_o);

   p_fl_mode_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'b01) |=> !boost_o);

   p_rs_mode_only_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i != 2'b10) |=> !(sync_o || resync_o));

endmodule

bind flk_resync_timer flk_resync_timer_chk #(.SEL_W(SEL_W)) u_chk (.*);

// File: tb/flk_resync_timer_tb.sv
`timescale 1ns/1ps
module flk_resync_timer_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  mode_i = 2'b00;
   logic [11:0] div_i = 12'd1;
   logic [11:0] mod_i = 12'd2;
   logic        le_i = 1'b0;
   logic [3:0]  muxsel_i = 4'd0;
   logic        boost_o, fl_sw_o, mux_gnd_o, sync_o, resync_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   flk_resync_timer u_dut (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .div_i(div_i), .mod_i(mod_i),
      .le_i(le_i), .muxsel_i(muxsel_i), .boost_o(boost_o), .fl_sw_o(fl_sw_o),
      .mux_gnd_o(mux_gnd_o), .sync_o(sync_o), .resync_o(resync_o));

   function automatic int unsigned eff_div(input logic [11:0] d);
      return (d == 0) ? 1 : int'(d);
   endfunction
   function automatic int unsigned eff_mod(input logic [11:0] m);
      return (m < 2) ? 2 : int'(m);
   endfunction

   task automatic check(input string req, input int act, input int exp_v);
      checks++;
      if (act != exp_v) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp_v, $time);
      end
   endtask

   // cycle reference built from the requirement text
   logic        m_le_q;
   int unsigned m_rem, m_k, m_seen;
   logic        m_sync, m_res;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_le_q = 0; m_rem = 0; m_k = 0; m_seen = 2; m_sync = 0; m_res = 0;
      end else begin
         logic rise;
         int unsigned p;
         rise   = le_i && !m_le_q;
         m_le_q = le_i;
         p      = eff_div(div_i) * eff_mod(mod_i);
         if (mode_i != 2'b01) m_rem = 0;
         else if (rise)       m_rem = eff_div(div_i);
         else if (m_rem > 0)  m_rem--;
         m_sync = 0; m_res = 0;
         if (mode_i != 2'b10) begin m_k = 0; m_seen = 2; end
         else if (rise)       begin m_k = 0; m_seen = 0; end
         else begin
            m_k++;
            if (m_k == p) begin
               m_k = 0; m_sync = 1;
               if (m_seen == 1) m_res = 1;
               if (m_seen < 2) m_seen++;
            end
         end
      end
   end

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         check("R2 boost", int'(boost_o), int'(m_rem > 0));
         check("R3 switch", int'(fl_sw_o), int'(m_rem > 0));
         check("R5 ground", int'(mux_gnd_o), int'((m_rem > 0) && muxsel_i == 4'b1100));
         check("R6 sync", int'(sync_o), int'(m_sync));
         check("R7 resync", int'(resync_o), int'(m_res));
      end
   end

   task automatic pulse_le();
      @(negedge clk) le_i = 1'b1;
      @(posedge clk);
      #1 le_i = 1'b0;
   endtask

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #900000;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      int hi, idx_s1, idx_s2, idx_r, nres;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      // R1: reset holds outputs low
      check("R1 reset", int'(boost_o | fl_sw_o | mux_gnd_o | sync_o | resync_o), 0);
      @(negedge clk) rst_n = 1'b1;
      step();
      check("R1 post-reset", int'(boost_o | sync_o | resync_o), 0);

      // R2/R5: 520-cycle window, ground routed
      @(negedge clk) begin mode_i = 2'b01; div_i = 12'd520; muxsel_i = 4'b1100; end
      pulse_le();
      hi = 0;
      for (int i = 0; i < 530; i++) begin
         if (boost_o) hi++;
         if (i == 3) check("R5 gnd routed", int'(mux_gnd_o), 1);
         step();
      end
      check("R2 window 520", hi, 520);

      // R2: zero divider counts as one
      @(negedge clk) div_i = 12'd0;
      pulse_le();
      hi = 0;
      for (int i = 0; i < 6; i++) begin if (boost_o) hi++; step(); end
      check("R2 zero clamp", hi, 1);

      // R4: restart mid-window
      @(negedge clk) begin div_i = 12'd10; muxsel_i = 4'b0011; end
      pulse_le();
      hi = 0;
      for (int i = 0; i < 6; i++) begin if (boost_o) hi++; step(); end
      check("R5 gnd blocked", int'(mux_gnd_o), 0);
      pulse_le();
      for (int i = 0; i < 20; i++) begin if (boost_o) hi++; step(); end
      check("R4 restart length", hi, 16);

      // R9: spare mode stays idle
      @(negedge clk) begin mode_i = 2'b11; div_i = 12'd2; mod_i = 12'd2; end
      pulse_le();
      hi = 0;
      for (int i = 0; i < 30; i++) begin
         if (boost_o | sync_o | resync_o | mux_gnd_o) hi++;
         step();
      end
      check("R9 spare idle", hi, 0);

      // R6/R7: N=3, M=5 gives P=15
      @(negedge clk) begin mode_i = 2'b10; div_i = 12'd3; mod_i = 12'd5; end
      pulse_le();
      idx_s1 = -1; idx_s2 = -1; idx_r = -1; nres = 0;
      for (int i = 0; i < 50; i++) begin
         if (sync_o && idx_s1 < 0) idx_s1 = i;
         else if (sync_o && idx_s2 < 0) idx_s2 = i;
         if (resync_o) begin nres++; idx_r = i; end
         step();
      end
      check("R6 first sync", idx_s1, 15);
      check("R6 period", idx_s2, 30);
      check("R7 resync index", idx_r, 30);
      check("R7 single resync", nres, 1);

      // R8: restart mid-period
      pulse_le();
      for (int i = 0; i < 7; i++) step();
      pulse_le();
      idx_s1 = -1;
      for (int i = 0; i < 20; i++) begin
         if (sync_o && idx_s1 < 0) idx_s1 = i;
         step();
      end
      check("R8 restart phase", idx_s1, 15);

      // randomized segments checked by the reference every cycle
      for (int seg = 0; seg < 400; seg++) begin
         int len;
         @(negedge clk) begin
            mode_i   = 2'($urandom % 4);
            div_i    = 12'($urandom % 7);
            mod_i    = 12'($urandom % 6);
            muxsel_i = ($urandom % 2) ? 4'b1100 : 4'($urandom % 16);
            le_i     = 1'b1;
         end
         len = 20 + int'($urandom % 40);
         for (int c = 0; c < len; c++) begin
            @(negedge clk) begin
               le_i = ($urandom % 12 == 0);
               if ($urandom % 5 == 0) muxsel_i = 4'($urandom % 16);
            end
         end
      end
      @(negedge clk) le_i = 1'b0;
      repeat (3) @(negedge clk);
      finish_run();
   end

endmodule